// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory instruction into a stream of per-lane element addresses. A single start pulse captures the addressing mode, a base byte address, a signed stride, the vector length and the element size. The block then emits one address group per beat, with one address for each of `NLANE` lanes. Each address comes with a 4-bit byte-enable mask that selects the element's bytes inside a 32-bit memory word.

Three addressing modes share the same datapath. In consecutive mode the addresses step by one element. In strided mode they step by a programmable number of elements. In gathered mode each address is the base plus a byte offset read from an index vector. The index vector is supplied one group at a time, and the block names the group it is consuming. Group timing is fixed, so the memory side can plan around it: a vector of VL elements completes in exactly 2·⌈VL/NLANE⌉+2 cycles.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset, `busy`, `out_valid`, `done` and `out_err` are 0, and `out_lane_en` and `out_be` are all zero.
- R2: With `mode`=0 (consecutive), element i has address base + i·S, where S = 1, 2 or 4 bytes for `esize` = 0, 1 or 2. The value 3 behaves as 2.
- R3: With `mode`=1 (strided), element i has address base + i·stride·S, where `stride` is a signed 16-bit element count.
- R4: With `mode`=2 (gathered), element i has address base + off(i), where off(i) is a signed byte offset. It is read from lane field l of `idx_vec` while `idx_grp` shows group k, for i = k·NLANE+l. `mode`=3 behaves as 0.
- R5: Element i = k·NLANE+l appears in lane l (address bits [l·32+31 : l·32]) of beat k. Lanes with i ≥ VL have `out_lane_en` bit 0 and an all-zero byte-enable nibble.
- R6: For an aligned active lane with low address bits a, the nibble `out_be`[4l+3:4l] is 1<<a for bytes, 3<<(2·a[1]) for halves and 4'hF for words.
- R7: An active lane whose address is not a multiple of S gets a zero byte-enable nibble, and `out_err` is high on that beat.
- R8: Count edges from the start edge as 0. Beat k is valid after edge 3+2k, one cycle wide. `done` is a single-cycle pulse after edge 2G+2, with G = ⌈VL/NLANE⌉. `busy` is high after edges 0 through 2G+1 and low from edge 2G+2.
- R9: A `start` pulse while `busy` is high is ignored. The running vector's addresses, enables and timing are unchanged.
- R10: With VL = 0 no beat is issued, and `done` pulses after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a vector; operands are captured at this edge |
| mode | input | 2 | 0 consecutive, 1 strided, 2 gathered, 3 as 0 |
| esize | input | 2 | Element size: 0 byte, 1 half, 2 word, 3 as 2 |
| base | input | 32 | Base byte address |
| stride | input | 16 | Signed stride in elements |
| vl | input | 7 | Vector length, 0 to 64 |
| idx_vec | input | 128 | Signed byte offsets for the group shown on idx_grp, 32 bits per lane |
| busy | output | 1 | Vector in progress |
| idx_grp | output | 5 | Group whose offsets are consumed next |
| out_valid | output | 1 | Address group valid |
| out_lane_en | output | 4 | Lanes holding live elements |
| out_addr | output | 128 | Lane byte addresses, 32 bits per lane |
| out_be | output | 16 | Byte enables, 4 bits per lane |
| out_err | output | 1 | A live lane is misaligned on this beat |
| done | output | 1 | One-cycle pulse after the last group |

## Verification
The hardest situation to reach is a second `start` that lands while a vector is in flight. The block must ignore it while its captured operands, group counter and remaining-element count go on as before. The sweep reaches this case by pulsing `start` again two edges into a run, with a different base, and still checks every beat against the first operands. Misalignment in gathered mode needs offsets that are not multiples of the element size. The bench's offset generator therefore adds a one-byte skew on chosen runs, so `out_err` and the zeroed masks show up on exact, predicted lanes.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    AM_CONSEC = 2'd0,
    AM_STRIDE = 2'd1,
    AM_GATHER = 2'd2,
    AM_SPARE  = 2'd3
  } amode_t;

  // log2 of the element size in bytes; code 3 behaves as a word
  function automatic logic [1:0] size_shift(input logic [1:0] esz);
    return (esz == 2'd3) ? 2'd2 : esz;
  endfunction

  function automatic logic misaligned(input logic [1:0] esz, input logic [1:0] lo);
    case (size_shift(esz))
      2'd0:    return 1'b0;
      2'd1:    return lo[0];
      default: return |lo;
    endcase
  endfunction

  function automatic logic [3:0] byte_mask(input logic [1:0] esz, input logic [1:0] lo);
    case (size_shift(esz))
      2'd0:    return 4'b0001 << lo;
      2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/vag_seq.sv
module vag_seq #(
  parameter int NLANE = 4,
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int MAXG = (MAXVL + NLANE - 1) / NLANE,
  localparam int GW   = $clog2(MAXG + 1),
  localparam int PW   = GW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  output logic           busy,
  output logic           launch,
  output logic           issue,
  output logic [GW-1:0]  grp,
  output logic           done
);

  logic [GW-1:0] ngrp;
  logic [PW-1:0] ph;
  logic [VLW:0]  vl_round;
  logic          fin;

  assign vl_round = {1'b0, vl} + (VLW+1)'(NLANE - 1);
  assign launch   = start && !busy;
  assign issue    = busy && (ph >= PW'(2)) && !ph[0] && (grp < ngrp);
  assign fin      = busy && (ph == PW'({ngrp, 1'b1}));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ph   <= '0;
      grp  <= '0;
      ngrp <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        ph   <= '0;
        grp  <= '0;
        ngrp <= GW'(vl_round / (VLW+1)'(NLANE));
      end else if (busy) begin
        ph <= ph + PW'(1);
        if (issue) grp <= grp + GW'(1);
        if (fin) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R8: the completion pulse is one cycle wide and ends the run
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r8_done_idle:  assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R8: every group has been issued by the time done appears
  a_r8_all_groups: assert property (@(posedge clk) disable iff (rst) done |-> grp == ngrp);
  // R9: group count of a running vector stays put even if start arrives
  a_r9_hold_count: assert property (@(posedge clk) disable iff (rst)
                                    (busy && !fin) |=> $stable(ngrp));

endmodule

// File: rtl/vag_lane.sv
module vag_lane
  import vag_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LANE = 0
) (
  input  logic [AW-1:0] gbase,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] off,
  input  logic          gather,
  input  logic [1:0]    esz,
  output logic [AW-1:0] addr,
  output logic [3:0]    be,
  output logic          mis
);

  logic [AW-1:0] lane_ofs;

  assign lane_ofs = step * AW'(LANE);
  assign addr     = gather ? (base + off) : (gbase + lane_ofs);
  assign mis      = misaligned(esz, addr[1:0]);
  assign be       = mis ? 4'b0000 : byte_mask(esz, addr[1:0]);

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter int NLANE = 4,
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int MAXG = (MAXVL + NLANE - 1) / NLANE,
  localparam int GW   = $clog2(MAXG + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic [1:0]          esize,
  input  logic [AW-1:0]       base,
  input  logic [SW-1:0]       stride,
  input  logic [VLW-1:0]      vl,
  input  logic [NLANE*AW-1:0] idx_vec,
  output logic                busy,
  output logic [GW-1:0]       idx_grp,
  output logic                out_valid,
  output logic [NLANE-1:0]    out_lane_en,
  output logic [NLANE*AW-1:0] out_addr,
  output logic [NLANE*4-1:0]  out_be,
  output logic                out_err,
  output logic                done
);

  logic          launch, issue;
  amode_t        mode_q;
  logic [1:0]    esz_q;
  logic [AW-1:0] base_q, step_q, gbase_q;
  logic [VLW-1:0] rem_q;
  logic [AW-1:0] step_in;
  amode_t        mode_in;

  logic [NLANE*AW-1:0] lane_addr;
  logic [NLANE*4-1:0]  lane_be;
  logic [NLANE-1:0]    lane_mis, lane_en;

  vag_seq #(.NLANE(NLANE), .MAXVL(MAXVL)) seq_i (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .busy(busy), .launch(launch), .issue(issue), .grp(idx_grp), .done(done)
  );

  // Byte step between neighbouring elements, fixed for the whole vector
  assign mode_in = amode_t'(mode);
  always_comb begin
    if (mode_in == AM_STRIDE)
      step_in = AW'($signed(stride)) << size_shift(esize);
    else
      step_in = AW'(1) << size_shift(esize);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= AM_CONSEC;
      esz_q   <= '0;
      base_q  <= '0;
      step_q  <= '0;
      gbase_q <= '0;
      rem_q   <= '0;
    end else if (launch) begin
      mode_q  <= mode_in;
      esz_q   <= esize;
      base_q  <= base;
      step_q  <= step_in;
      gbase_q <= base;
      rem_q   <= vl;
    end else if (issue) begin
      gbase_q <= gbase_q + step_q * AW'(NLANE);
      rem_q   <= (rem_q > VLW'(NLANE)) ? rem_q - VLW'(NLANE) : '0;
    end
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign lane_en[l] = rem_q > VLW'(l);
    vag_lane #(.AW(AW), .LANE(l)) lane_i (
      .gbase (gbase_q),
      .base  (base_q),
      .step  (step_q),
      .off   (idx_vec[l*AW +: AW]),
      .gather(mode_q == AM_GATHER),
      .esz   (esz_q),
      .addr  (lane_addr[l*AW +: AW]),
      .be    (lane_be[l*4 +: 4]),
      .mis   (lane_mis[l])
    );

    // R5: a lane without a live element never enables a byte
    a_r5_dead_lane: assert property (@(posedge clk) disable iff (rst)
                                     !out_lane_en[l] |-> out_be[l*4 +: 4] == 4'b0000);
    // R7: a live lane with no enabled byte must be flagged
    a_r7_flagged: assert property (@(posedge clk) disable iff (rst)
                                   (out_lane_en[l] && out_be[l*4 +: 4] == 4'b0000) |-> out_err);
  end

  always_ff @(posedge clk) begin
    if (rst || !issue) begin
      out_valid   <= 1'b0;
      out_lane_en <= '0;
      out_addr    <= '0;
      out_be      <= '0;
      out_err     <= 1'b0;
    end else begin
      out_valid   <= 1'b1;
      out_lane_en <= lane_en;
      out_addr    <= lane_addr;
      for (int l = 0; l < NLANE; l++)
        out_be[l*4 +: 4] <= lane_en[l] ? lane_be[l*4 +: 4] : 4'b0000;
      out_err     <= |(lane_mis & lane_en);
    end
  end

  // R8: beats are never back to back
  a_r8_spacing: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);
  // R7: an error only accompanies a valid beat
  a_r7_err_valid: assert property (@(posedge clk) disable iff (rst) out_err |-> out_valid);
  // R5: a valid beat carries at least lane 0
  a_r5_lane0: assert property (@(posedge clk) disable iff (rst) out_valid |-> out_lane_en[0]);

endmodule

// File: tb/vec_addr_gen_tb_top.sv
module vec_addr_gen_tb_top;

  localparam int AW = 32, SW = 16, NLANE = 4, MAXVL = 64;
  localparam int VLW = $clog2(MAXVL + 1);
  localparam int GW  = $clog2((MAXVL + NLANE - 1) / NLANE + 1);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] mode = '0, esize = '0;
  logic [AW-1:0] base = '0;
  logic [SW-1:0] stride = '0;
  logic [VLW-1:0] vl = '0;
  logic [NLANE*AW-1:0] idx_vec;
  logic busy, out_valid, out_err, done;
  logic [GW-1:0] idx_grp;
  logic [NLANE-1:0] out_lane_en;
  logic [NLANE*AW-1:0] out_addr;
  logic [NLANE*4-1:0] out_be;

  int total = 0, bad = 0;
  int ix_mul = 3, ix_add = -5, ix_skew = 0;
  logic [1:0] ix_esz = 2'd0;

  always #10 clk = ~clk;

  vec_addr_gen #(.AW(AW), .SW(SW), .NLANE(NLANE), .MAXVL(MAXVL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .esize(esize), .base(base),
    .stride(stride), .vl(vl), .idx_vec(idx_vec), .busy(busy), .idx_grp(idx_grp),
    .out_valid(out_valid), .out_lane_en(out_lane_en), .out_addr(out_addr),
    .out_be(out_be), .out_err(out_err), .done(done)
  );

  function automatic int sz_of(input logic [1:0] e);
    return (e == 2'd0) ? 1 : (e == 2'd1) ? 2 : 4;
  endfunction

  function automatic longint offset_of(input int i);
    return longint'(i * ix_mul + ix_add) * sz_of(ix_esz) + ix_skew;
  endfunction

  always_comb
    for (int l = 0; l < NLANE; l++)
      idx_vec[l*AW +: AW] = AW'(offset_of(int'(idx_grp) * NLANE + l));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic [1:0] e, input logic [AW-1:0] b,
                        input int st, input int n, input bit restart);
    int g, sz, stp;
    string rq;
    g  = (n + NLANE - 1) / NLANE;
    sz = sz_of(e);
    stp = (m == 2'd1) ? st : 1;
    rq = (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R2";
    ix_esz = e;
    @(negedge clk);
    mode = m; esize = e; base = b; stride = SW'(st); vl = VLW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
    for (int c = 1; c <= 2 * g + 3; c++) begin
      bit ev, ed, eb;
      @(negedge clk);
      if (restart && c == 1) begin
        start = 1'b1; base = b + 32'd64; mode = 2'd0;
      end else begin
        start = 1'b0;
      end
      ev = (c >= 3) && (c % 2 == 1) && ((c - 3) / 2 < g);
      ed = (c == 2 * g + 2);
      eb = (c <= 2 * g + 1);
      check(out_valid == ev && done == ed && busy == eb, (n == 0) ? "R10" : (restart ? "R9" : "R8"),
            "valid/done/busy", {out_valid, done, busy}, {ev, ed, eb});
      if (ev) begin
        int k;
        bit eerr;
        k = (c - 3) / 2;
        eerr = 1'b0;
        for (int l = 0; l < NLANE; l++) begin
          int i;
          longint ea;
          logic [AW-1:0] a32;
          logic [3:0] ebe;
          bit live, mis;
          i = k * NLANE + l;
          live = (i < n);
          if (m == 2'd2) ea = longint'(b) + offset_of(i);
          else ea = longint'(b) + longint'(i) * stp * sz;
          a32 = AW'(ea);
          mis = (sz == 2 && a32[0]) || (sz == 4 && a32[1:0] != 2'b00);
          if (!live || mis) ebe = 4'b0000;
          else if (sz == 1) ebe = 4'b0001 << a32[1:0];
          else if (sz == 2) ebe = a32[1] ? 4'b1100 : 4'b0011;
          else ebe = 4'b1111;
          if (live && mis) eerr = 1'b1;
          check(out_lane_en[l] == live, "R5", "lane enable", out_lane_en[l], live);
          if (live)
            check(out_addr[l*AW +: AW] == a32, restart ? "R9" : rq, "lane address",
                  out_addr[l*AW +: AW], a32);
          check(out_be[l*4 +: 4] == ebe, mis ? "R7" : "R6", "byte enables",
                out_be[l*4 +: 4], ebe);
        end
        check(out_err == eerr, "R7", "error flag", out_err, eerr);
      end
    end
    start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int vls[7] = '{0, 1, 3, 4, 5, 8, 13};
    int strs[3] = '{1, -2, 3};
    logic [AW-1:0] bases[3] = '{32'h0000_1000, 32'h0000_2002, 32'hFFFF_FFF1};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle state after reset
    check(busy == 0 && out_valid == 0 && done == 0 && out_err == 0 &&
          out_lane_en == '0 && out_be == '0, "R1", "reset state",
          {busy, out_valid, done, out_err}, 0);
    for (int e = 0; e < 4; e++)
      for (int bi = 0; bi < 3; bi++)
        for (int vi = 0; vi < 7; vi++) begin
          run_op(2'd0, 2'(e), bases[bi], 0, vls[vi], 1'b0);   // R2
          run_op(2'd3, 2'(e), bases[bi], 0, vls[vi], 1'b0);   // R4: spare code as consecutive
          for (int si = 0; si < 3; si++)
            run_op(2'd1, 2'(e), bases[bi], strs[si], vls[vi], 1'b0); // R3
          ix_skew = 0;
          run_op(2'd2, 2'(e), bases[bi], 0, vls[vi], 1'b0);   // R4
          ix_skew = 1;
          run_op(2'd2, 2'(e), bases[bi], 0, vls[vi], 1'b0);   // R7 via skewed offsets
          ix_skew = 0;
        end
    // R9: restart attempts during a run, including a full-length vector
    run_op(2'd1, 2'd1, 32'h0000_4000, -3, 13, 1'b1);
    run_op(2'd2, 2'd2, 32'h0000_8000, 0, 64, 1'b1);
    run_op(2'd0, 2'd0, 32'h0000_0003, 0, 64, 1'b1);
    // R10: empty vector right after another
    run_op(2'd0, 2'd2, 32'h0000_0010, 0, 0, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule